// File: doc/BRIEF.md
# Flow-through zero-turnaround synchronous SRAM

This block is a cycle-accurate, synthesizable model of a synchronous burst SRAM. Reads are flow-through and writes are late. A read command registered on a rising edge presents array data during the cycle that follows. A write command registered on an edge takes its data from the bus on the next enabled edge. That same edge may register a new command, so reads and writes can alternate on every cycle with no dead cycles. A two-bit burst counter steps the low address bits for up to four beats, in linear or in XOR order as the order strap selects. A clock-enable input freezes the whole block. A sleep input parks the device.

The shared data bus is split into `dq_in`, `dq_out` and an active-high driver enable `dq_oe`. A pad ring or a bench joins them. All timing is fixed by the clock, so the bus has no valid/ready handshake and no back-pressure. A caller that cannot supply or take a beat holds `clk_en_n` high instead. The array depth is set by the address width parameter.

Top module: `zt_sram`

## Requirements
- R1: On an edge with `clk_en_n`=0, `burst_go`=0 and all chip enables active (`en_a_n`=0, `en_b`=1, `en_c_n`=0), the block starts an access: a read when `write_n`=1, a write when `write_n`=0. After a read edge, `dq_out` carries the addressed word in the same cycle. The same kind of edge with any chip enable inactive deselects the block.
- R2: Write data is taken from `dq_in` on the first enabled edge after the edge that registered the write address. A read of the same address issued on that edge returns the newly written bytes.
- R3: An edge with `clk_en_n`=1 changes no state and performs no write. The outputs of the current cycle are held.
- R4: On an enabled edge with `burst_go`=1 while an access is active, the chip enables and `write_n` are ignored, the burst counter advances, and the access type is kept.
- R5: With `order_xor`=0, beat k of a burst uses low address bits (start+k) mod 4, for example 01,10,11,00.
- R6: With `order_xor`=1, beat k uses low address bits start XOR k, for example 01,00,11,10.
- R7: `lane_mask_n[i]`=0 writes bits [8i+7:8i] of the beat. Lanes left high keep their contents, and a beat with all four bits high writes nothing. The mask is sampled with each command or burst edge.
- R8: `dq_oe` is 0 during a write data phase, and it is 0 whenever `out_en_n`=1. `out_en_n` acts without a clock.
- R9: After reset the block is deselected with `dq_oe`=0. While deselected, an edge with `burst_go`=1 keeps it deselected.
- R10: Raising `doze` drops `dq_oe` at once. From the second edge after the rise, every access is dropped and the block is deselected. The first two edges after `doze` falls are still ignored. Array contents survive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset to the deselected state |
| clk_en_n | input | 1 | Active-low clock qualifier; high freezes the block |
| en_a_n | input | 1 | Chip enable, active low |
| en_b | input | 1 | Chip enable, active high |
| en_c_n | input | 1 | Chip enable, active low |
| burst_go | input | 1 | 0 loads a new command, 1 advances the burst |
| write_n | input | 1 | 0 write, 1 read, sampled at load |
| lane_mask_n | input | LANES | Active-low byte lane write selects |
| addr | input | AW | Word address |
| order_xor | input | 1 | Burst order strap: 0 linear, 1 XOR |
| out_en_n | input | 1 | Asynchronous active-low output enable |
| doze | input | 1 | Sleep request, active high |
| dq_in | input | LANES*LW | Data bus, inbound half |
| dq_out | output | LANES*LW | Data bus, outbound half |
| dq_oe | output | 1 | Bus driver enable |

## Verification
The interesting collision is an edge that completes a pending write's data phase and also registers a read of the same word with a different lane mask. Only the written lanes may change, and they must show up on `dq_out` right after that edge. The bench provokes this both with directed sequences and with a long random mix of loads, burst beats, stalls and deselects. It judges every cycle against its own reference array and its own reference model of the pipeline. A second overlap is a stall that lands inside a burst or a pending write. The bench checks that the held output and the later data phase both behave as if the stalled edge never happened.

// File: rtl/zts_pkg.sv
package zts_pkg;
  // Low address bits of beat k for a burst that started at 'start'.
  function automatic logic [1:0] beat_offset(input logic [1:0] start,
                                             input logic [1:0] beat,
                                             input logic       xor_mode);
    return xor_mode ? (start ^ beat) : (start + beat);
  endfunction
endpackage

// File: rtl/zts_sleep.sv
module zts_sleep (
  input  logic clk,
  input  logic rst_n,
  input  logic doze,
  output logic dormant,
  output logic quiet
);
  logic s1, s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else begin
      s1 <= doze;
      s2 <= s1;
    end
  end

  assign dormant = s2;
  assign quiet   = doze | s1 | s2;

  // R10: two edges of sustained sleep request leave the device dormant
  p_entry_two_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(doze) && $past(doze, 2)) |-> dormant);
endmodule

// File: rtl/zts_ctrl.sv
module zts_ctrl #(
  parameter int AW    = 8,
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en_n,
  input  logic             sel,
  input  logic             adv,
  input  logic             write_n,
  input  logic [LANES-1:0] lane_n,
  input  logic [AW-1:0]    addr,
  input  logic             order_xor,
  input  logic             dormant,
  output logic             active,
  output logic             is_wr,
  output logic [AW-1:0]    addr_q,
  output logic [LANES-1:0] lane_q,
  output logic             wr_go
);
  import zts_pkg::*;

  logic [1:0] base;
  logic [1:0] step;
  logic [1:0] step_nx;

  assign step_nx = step + 2'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      is_wr  <= 1'b0;
      base   <= '0;
      step   <= '0;
      addr_q <= '0;
      lane_q <= '1;
    end else if (dormant) begin
      active <= 1'b0;
    end else if (!clk_en_n) begin
      lane_q <= lane_n;
      if (!adv) begin
        if (sel) begin
          active <= 1'b1;
          is_wr  <= ~write_n;
          base   <= addr[1:0];
          step   <= '0;
          addr_q <= addr;
        end else begin
          active <= 1'b0;
        end
      end else if (active) begin
        step        <= step_nx;
        addr_q[1:0] <= beat_offset(base, step_nx, order_xor);
      end
    end
  end

  // Data phase of the registered write completes on the next live edge.
  assign wr_go = !clk_en_n && active && is_wr && !dormant;

  // R3: a stalled edge leaves every register unchanged
  p_stall_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en_n && !dormant) |=> $stable({active, is_wr, addr_q, lane_q, step}));

  // R4: burst continuation keeps the access type and the upper address
  p_burst_keeps_type_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !dormant && adv && active)
      |=> (active && $stable(is_wr) && $stable(addr_q[AW-1:2])));

  // R9: advance while deselected keeps the device deselected
  p_idle_stays_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!dormant && adv && !active) |=> !active);

  // R5: linear order moves the low bits up by one per beat
  p_lin_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !dormant && adv && active && !order_xor)
      |=> (addr_q[1:0] == $past(addr_q[1:0]) + 2'd1));

  // R6: XOR order relates the low bits to the start offset by the beat count
  p_ilv_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !dormant && adv && active && order_xor)
      |=> ((addr_q[1:0] ^ base) == $past(step) + 2'd1));
endmodule

// File: rtl/zts_array.sv
module zts_array #(
  parameter int AW    = 8,
  parameter int LANES = 4,
  parameter int LW    = 8
) (
  input  logic                clk,
  input  logic                we,
  input  logic [AW-1:0]       addr,
  input  logic [LANES-1:0]    lane_n,
  input  logic [LANES*LW-1:0] wdata,
  output logic [LANES*LW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
      if (we && !lane_n[g]) cells[addr] <= wdata[g*LW +: LW];
    end

    assign rdata[g*LW +: LW] = cells[addr];
  end
endmodule

// File: rtl/zt_sram.sv
module zt_sram #(
  parameter int AW    = 8,
  parameter int LANES = 4,
  parameter int LW    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clk_en_n,
  input  logic                en_a_n,
  input  logic                en_b,
  input  logic                en_c_n,
  input  logic                burst_go,
  input  logic                write_n,
  input  logic [LANES-1:0]    lane_mask_n,
  input  logic [AW-1:0]       addr,
  input  logic                order_xor,
  input  logic                out_en_n,
  input  logic                doze,
  input  logic [LANES*LW-1:0] dq_in,
  output logic [LANES*LW-1:0] dq_out,
  output logic                dq_oe
);
  logic             sel;
  logic             dormant, quiet;
  logic             active, is_wr, wr_go;
  logic [AW-1:0]    addr_q;
  logic [LANES-1:0] lane_q;

  assign sel = !en_a_n && en_b && !en_c_n;

  zts_sleep u_sleep (
    .clk     (clk),
    .rst_n   (rst_n),
    .doze    (doze),
    .dormant (dormant),
    .quiet   (quiet)
  );

  zts_ctrl #(.AW(AW), .LANES(LANES)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_en_n  (clk_en_n),
    .sel       (sel),
    .adv       (burst_go),
    .write_n   (write_n),
    .lane_n    (lane_mask_n),
    .addr      (addr),
    .order_xor (order_xor),
    .dormant   (dormant),
    .active    (active),
    .is_wr     (is_wr),
    .addr_q    (addr_q),
    .lane_q    (lane_q),
    .wr_go     (wr_go)
  );

  // The write commits on the same edge that may register a read, so a
  // following read of that word sees the merged bytes with no bypass mux.
  zts_array #(.AW(AW), .LANES(LANES), .LW(LW)) u_array (
    .clk    (clk),
    .we     (wr_go),
    .addr   (addr_q),
    .lane_n (lane_q),
    .wdata  (dq_in),
    .rdata  (dq_out)
  );

  assign dq_oe = !out_en_n && active && !is_wr && !quiet;

  // R10: a sleep request silences the bus
  p_sleep_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    doze |-> !dq_oe);

  // R8: output enable high never drives
  p_oe_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n |-> !dq_oe);

  // R8: no driving while a write data phase is on the bus
  p_write_phase_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |-> !dq_oe);
endmodule

// File: tb/sim_zt_sram.sv
`timescale 1ns/1ps
module sim_zt_sram;
  localparam int AW = 8, LANES = 4, LW = 8, DW = LANES*LW, DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, clk_en_n, en_a_n, en_b, en_c_n, burst_go, write_n;
  logic [LANES-1:0] lane_mask_n;
  logic [AW-1:0] addr;
  logic order_xor, out_en_n, doze;
  logic [DW-1:0] dq_in, dq_out;
  logic dq_oe;

  zt_sram #(.AW(AW), .LANES(LANES), .LW(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .en_a_n(en_a_n), .en_b(en_b),
    .en_c_n(en_c_n), .burst_go(burst_go), .write_n(write_n),
    .lane_mask_n(lane_mask_n), .addr(addr), .order_xor(order_xor),
    .out_en_n(out_en_n), .doze(doze), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  string last_tag;

  // reference state
  logic [DW-1:0] gold [DEPTH];
  bit m_act, m_wr, m_cont, m_ilv, m_s1, m_s2;
  logic [1:0] m_base, m_k;
  logic [AW-1:0] m_addr;
  logic [LANES-1:0] m_lane;

  // stimulus table: cen_n cs adv wr_n lane[4] addr[8] oe_n mode exp_oe pad
  localparam int NT = 21;
  localparam logic [19:0] TBL [NT] = '{
    {1'b0,1'b1,1'b0,1'b0,4'h0,8'h10,1'b0,1'b0,1'b0,1'b0}, // write load 0x10
    {1'b0,1'b0,1'b1,1'b1,4'h0,8'h00,1'b0,1'b0,1'b0,1'b0}, // R4 beat, enables ignored
    {1'b0,1'b0,1'b1,1'b1,4'h0,8'h00,1'b0,1'b0,1'b0,1'b0},
    {1'b0,1'b0,1'b1,1'b1,4'h0,8'h00,1'b0,1'b0,1'b0,1'b0},
    {1'b0,1'b1,1'b0,1'b1,4'hF,8'h10,1'b0,1'b0,1'b1,1'b0}, // read 0x10, last write commits
    {1'b0,1'b1,1'b1,1'b0,4'hF,8'h00,1'b0,1'b0,1'b1,1'b0}, // 0x11
    {1'b1,1'b1,1'b0,1'b0,4'hF,8'h00,1'b0,1'b0,1'b1,1'b0}, // stall holds read
    {1'b0,1'b1,1'b1,1'b0,4'hF,8'h00,1'b0,1'b0,1'b1,1'b0}, // 0x12
    {1'b0,1'b1,1'b1,1'b0,4'hF,8'h00,1'b0,1'b0,1'b1,1'b0}, // 0x13
    {1'b0,1'b1,1'b1,1'b0,4'hF,8'h00,1'b0,1'b0,1'b1,1'b0}, // wraps to 0x10
    {1'b0,1'b1,1'b0,1'b1,4'hF,8'h12,1'b1,1'b0,1'b0,1'b0}, // read, output enable high
    {1'b0,1'b0,1'b0,1'b1,4'hF,8'h12,1'b0,1'b0,1'b0,1'b0}, // deselect
    {1'b0,1'b1,1'b1,1'b1,4'hF,8'h00,1'b0,1'b0,1'b0,1'b0}, // continue deselect
    {1'b0,1'b1,1'b0,1'b0,4'hA,8'h21,1'b0,1'b1,1'b0,1'b0}, // xor write, lanes 0 and 2
    {1'b0,1'b1,1'b1,1'b0,4'hA,8'h00,1'b0,1'b1,1'b0,1'b0}, // 0x20
    {1'b0,1'b1,1'b0,1'b1,4'hF,8'h21,1'b0,1'b1,1'b1,1'b0}, // read 0x21
    {1'b0,1'b1,1'b1,1'b1,4'hF,8'h00,1'b0,1'b1,1'b1,1'b0}, // 0x20
    {1'b0,1'b1,1'b1,1'b1,4'hF,8'h00,1'b0,1'b1,1'b1,1'b0}, // 0x23
    {1'b0,1'b1,1'b0,1'b0,4'hF,8'h21,1'b0,1'b0,1'b0,1'b0}, // write abort
    {1'b0,1'b1,1'b0,1'b1,4'hF,8'h21,1'b0,1'b0,1'b1,1'b0}, // read unchanged
    {1'b0,1'b0,1'b0,1'b1,4'hF,8'h00,1'b0,1'b0,1'b0,1'b0}  // deselect
  };

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp, input string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input bit cen_n, input bit cs, input bit adv, input bit wn,
                     input logic [LANES-1:0] ln, input logic [AW-1:0] a,
                     input bit oen, input bit md, input bit slp, input logic [DW-1:0] wd);
    bit exp_oe, quiet;
    logic [1:0] lo;
    string dt;
    @(negedge clk);
    clk_en_n = cen_n;
    if (cs) {en_a_n, en_b, en_c_n} = 3'b010;
    else case ($urandom % 3)
      0: {en_a_n, en_b, en_c_n} = 3'b110;
      1: {en_a_n, en_b, en_c_n} = 3'b000;
      default: {en_a_n, en_b, en_c_n} = 3'b011;
    endcase
    burst_go = adv; write_n = wn; lane_mask_n = ln; addr = a;
    out_en_n = oen; order_xor = md; doze = slp; dq_in = wd;
    if (m_s2) m_act = 0;
    else if (!cen_n) begin
      if (m_act && m_wr)
        for (int i = 0; i < LANES; i++)
          if (!m_lane[i]) gold[m_addr][i*LW +: LW] = wd[i*LW +: LW];
      if (!adv) begin
        if (cs) begin
          m_act = 1; m_wr = !wn; m_base = a[1:0]; m_k = 0; m_cont = 0;
          m_ilv = md; m_addr = a;
        end else m_act = 0;
      end else if (m_act) begin
        m_k = m_k + 2'd1; m_cont = 1; m_ilv = md;
        lo = md ? (m_base ^ m_k) : (m_base + m_k);
        m_addr = {m_addr[AW-1:2], lo};
      end
      m_lane = ln;
    end
    m_s2 = m_s1; m_s1 = slp;
    @(posedge clk); #1;
    quiet = slp || m_s1 || m_s2;
    exp_oe = !oen && m_act && !m_wr && !quiet;
    if (quiet) last_tag = "R10";
    else if (cen_n) last_tag = "R3";
    else if (!m_act) last_tag = "R9";
    else if (m_wr || oen) last_tag = "R8";
    else if (m_cont) last_tag = "R4";
    else last_tag = "R1";
    chk(dq_oe === exp_oe, last_tag, DW'(dq_oe), DW'(exp_oe), "drive");
    if (exp_oe) begin
      if (cen_n) dt = "R3";
      else if (m_k == 0) dt = "R1";
      else if (m_ilv) dt = "R6";
      else dt = "R5";
      chk(dq_out === gold[m_addr], dt, dq_out, gold[m_addr], "read data");
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] x, y, z, w1, w2, merged;
    rst_n = 0; clk_en_n = 0; en_a_n = 1; en_b = 0; en_c_n = 1; burst_go = 0;
    write_n = 1; lane_mask_n = '1; addr = '0; order_xor = 0; out_en_n = 0;
    doze = 0; dq_in = '0;
    m_act = 0; m_wr = 0; m_cont = 0; m_ilv = 0; m_s1 = 0; m_s2 = 0;
    m_base = 0; m_k = 0; m_addr = '0; m_lane = '1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #0.5;
    chk(dq_oe === 1'b0, "R9", DW'(dq_oe), '0, "reset drive");
    // R9: advance while deselected stays deselected
    cyc(0, 1, 1, 1, '1, '0, 0, 0, 0, '0);
    cyc(0, 1, 1, 1, '1, '0, 0, 0, 0, '0);

    // prefill every word with linear 4-beat write bursts
    for (int b = 0; b < DEPTH/4; b++) begin
      cyc(0, 1, 0, 0, '0, AW'(b*4), 1, 0, 0, $urandom);
      for (int k = 1; k < 4; k++) cyc(0, 0, 1, 1, '0, '0, 1, 0, 0, $urandom);
    end

    // table walk
    for (int i = 0; i < NT; i++) begin
      cyc(TBL[i][19], TBL[i][18], TBL[i][17], TBL[i][16], TBL[i][15:12],
          TBL[i][11:4], TBL[i][3], TBL[i][2], 1'b0, $urandom);
      chk(dq_oe === TBL[i][1], last_tag, DW'(dq_oe), DW'(TBL[i][1]), "table drive");
    end

    // R2: read issued on the data-phase edge of a write to the same word
    cyc(0, 1, 0, 0, '0, 8'h60, 1, 0, 0, $urandom);
    x = 32'hA5C3_0F96;
    cyc(0, 1, 0, 1, '1, 8'h60, 0, 0, 0, x);
    chk(dq_oe === 1'b1 && dq_out === x, "R2", dq_out, x, "write-then-read");

    // R7: partial lane write merges, all-high mask writes nothing
    x = 32'h1122_3344; y = 32'hAABB_CCDD; z = 32'h5566_7788;
    cyc(0, 1, 0, 0, '0, 8'h50, 1, 0, 0, $urandom);
    cyc(0, 1, 0, 0, 4'b1010, 8'h50, 1, 0, 0, x);
    cyc(0, 1, 0, 1, '1, 8'h50, 0, 0, 0, y);
    merged = {x[31:24], y[23:16], x[15:8], y[7:0]};
    chk(dq_out === merged, "R7", dq_out, merged, "lane merge");
    cyc(0, 1, 0, 0, 4'b1111, 8'h50, 1, 0, 0, $urandom);
    cyc(0, 1, 0, 1, '1, 8'h50, 0, 0, 0, z);
    chk(dq_out === merged, "R7", dq_out, merged, "masked write");

    // R3: stalled edge does not take write data
    w1 = 32'hDEAD_0001; w2 = 32'hBEEF_0002;
    cyc(0, 1, 0, 0, '0, 8'h70, 1, 0, 0, $urandom);
    cyc(1, 0, 0, 1, '1, 8'h00, 0, 0, 0, w1);
    cyc(0, 1, 0, 1, '1, 8'h70, 0, 0, 0, w2);
    chk(dq_out === w2, "R3", dq_out, w2, "stall write data");
    cyc(1, 0, 0, 0, '0, 8'h33, 0, 1, 0, w1);
    chk(dq_oe === 1'b1 && dq_out === w2, "R3", dq_out, w2, "stall read hold");

    // R10: sleep entry and exit
    cyc(0, 1, 0, 1, '1, 8'h70, 0, 0, 1, '0);
    chk(dq_oe === 1'b0, "R10", DW'(dq_oe), '0, "drive at sleep rise");
    for (int k = 0; k < 3; k++) cyc(0, 1, 0, 1, '1, 8'h70, 0, 0, 1, '0);
    cyc(0, 1, 0, 1, '1, 8'h70, 0, 0, 0, '0);
    cyc(0, 1, 0, 1, '1, 8'h70, 0, 0, 0, '0);
    chk(dq_oe === 1'b0, "R10", DW'(dq_oe), '0, "second edge after wake ignored");
    cyc(0, 1, 0, 1, '1, 8'h70, 0, 0, 0, '0);
    chk(dq_oe === 1'b1 && dq_out === w2, "R10", dq_out, w2, "contents kept");

    // random mix
    begin
      bit md = 0;
      for (int n = 0; n < 2500; n++) begin
        int r = $urandom % 16;
        logic [LANES-1:0] ln = ($urandom % 3 == 0) ? LANES'($urandom) : '0;
        bit oen = ($urandom % 8 == 0);
        if (r < 2) cyc(1, $urandom, $urandom, $urandom, ln, AW'($urandom), oen, md, 0, $urandom);
        else if (r == 2) cyc(0, 0, 0, $urandom, ln, AW'($urandom), oen, md, 0, $urandom);
        else if (r < 9) begin
          md = $urandom;
          cyc(0, 1, 0, 1, ln, AW'($urandom), oen, md, 0, $urandom);
        end else if (r < 12) begin
          md = $urandom;
          cyc(0, 1, 0, 0, ln, AW'($urandom), oen, md, 0, $urandom);
        end else cyc(0, $urandom, 1, $urandom, ln, AW'($urandom), oen, md, 0, $urandom);
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule